// File: doc/BRIEF.md
# Host Register Port with Reconfigurable Strobes

This block is the processor-facing side of a data converter. A host reaches it over a 10-bit parallel data path, a pair of chip selects of opposite polarity and a 2-bit register address. Writes load one of two 10-bit control registers. Reads return the word at the head of the sample FIFO and release that word once the read ends. All pins are sampled on the system clock, and every access is recognised from the sampled levels, so an access must last at least two clock periods.

The shared strobe pin has two roles. In combined mode it is a read/write level: with the port selected, high means read and low means write, and the selection itself frames the access. In split mode the same pin is an active-low write strobe, and a separate active-low read strobe handles reads. Bit 0 of control register 1 picks the mode. After reset the mode is not yet trusted. Until the first write completes, any read attempt returns zero and leaves the FIFO untouched. The data pins come out as an input bus, an output bus and an output enable for the pad ring.

Top module: `hif_host_port`

## Requirements
- R1: After reset both control registers are 0, the output enable is low, the output bus is 0 and no FIFO pop is issued.
- R2: The port is selected only while selLoN is 0 and selHi is 1. Outside that condition no access happens: registers stay unchanged and the bus is not driven.
- R3: In combined mode, a selected access with rwPin low is a write. The word and the address sampled during the write are loaded when the access ends, either by selLoN rising or by selHi falling. Address 0 loads control register 0 and address 1 loads control register 1.
- R4: A write to address 2 or 3 changes neither control register.
- R5: Bit 0 of control register 1 selects the strobe mode: 0 is combined, 1 is split. In split mode, a selection with rwPin high and rdPinN high does not read.
- R6: In combined mode, a selected access with rwPin high is a read. It raises busOe and presents the FIFO head on busOut. fifoPop pulses for one clock after the access ends.
- R7: In split mode, a write is framed by rwPin low while selected. It is loaded when rwPin rises or when the selection ends.
- R8: In split mode, a read is framed by rdPinN low with rwPin high while selected. It drives the FIFO head and pops once after rdPinN rises.
- R9: In combined mode, rdPinN has no effect: it neither starts a read nor blocks a write.
- R10: Until the first write has completed after reset, a selected access with rwPin high drives busOe high with busOut 0 and issues no pop. Any completed write, to any address, ends this state.
- R11: busOut is 0 whenever busOe is low.
- R12: A read of any length produces exactly one single-cycle fifoPop.
- R13: In split mode, rwPin low together with rdPinN low is a write only: the bus is not driven and no pop follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selLoN | input | 1 | Chip select, active low |
| selHi | input | 1 | Chip select, active high |
| regSel | input | 2 | Register address for writes |
| rwPin | input | 1 | Read/write level (combined) or write strobe, active low (split) |
| rdPinN | input | 1 | Read strobe, active low, used in split mode only |
| busIn | input | 10 | Data from the host, bit 0 is the LSB |
| busOut | output | 10 | Data to the host |
| busOe | output | 1 | Pad output enable for busOut |
| fifoHead | input | 10 | Word at the FIFO head |
| fifoPop | output | 1 | One-cycle request to drop the FIFO head |
| ctrlReg0 | output | 10 | Control register 0 |
| ctrlReg1 | output | 10 | Control register 1, bit 0 is the strobe mode |

## Verification
In split mode, the end of a write and the start of a read can fall in the same clock cycle. The bench provokes this by raising the write strobe and lowering the read strobe on the same clock edge, with the port still selected. It then expects three results: the written register holds the new word, the bus carries the FIFO head while the read strobe stays low, and exactly one pop follows once the read strobe rises.

// File: rtl/hif_pkg.sv
package hif_pkg;

  localparam int HIF_DATA_W = 10;
  localparam int HIF_ADDR_W = 2;
  localparam int HIF_NUM_REGS = 2;

  typedef enum logic {
    HIF_UNINIT = 1'b0,
    HIF_READY  = 1'b1
  } hifCfg_t;

  typedef struct packed {
    logic selLoN;
    logic selHi;
    logic rwPin;
    logic rdPinN;
  } hifPins_t;

  typedef struct packed {
    logic wrActive;
    logic wrCommit;
    logic rdDrive;
    logic rdZero;
    logic popPulse;
  } hifStrobe_t;

endpackage

// File: rtl/hif_ctrl.sv
module hif_ctrl
  import hif_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selLoN,
  input  logic       selHi,
  input  logic       rwPin,
  input  logic       rdPinN,
  input  logic       sepMode,
  output hifStrobe_t strb
);

  localparam hifPins_t PINS_IDLE = '{selLoN: 1'b1, selHi: 1'b0, rwPin: 1'b1, rdPinN: 1'b1};

  hifPins_t pinQ;
  hifCfg_t  cfgQ;
  logic     wrWinQ;
  logic     rdWinQ;
  logic     rdZeroQ;

  logic selNow;
  logic wrWin;
  logic rdWin;
  logic rdStart;
  logic wrCommit;
  logic cfgNow;
  logic popPulse;

  // pin sampling stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ <= PINS_IDLE;
    end else begin
      pinQ <= '{selLoN: selLoN, selHi: selHi, rwPin: rwPin, rdPinN: rdPinN};
    end
  end

  // access windows from sampled levels
  always_comb begin
    selNow = !pinQ.selLoN && pinQ.selHi;
    wrWin  = selNow && !pinQ.rwPin;
    if (cfgQ == HIF_UNINIT || !sepMode) begin
      rdWin = selNow && pinQ.rwPin;
    end else begin
      rdWin = selNow && pinQ.rwPin && !pinQ.rdPinN;
    end
  end

  assign wrCommit = wrWinQ && !wrWin;
  assign cfgNow   = (cfgQ == HIF_READY) || wrCommit;
  assign rdStart  = rdWin && !rdWinQ;
  assign popPulse = rdWinQ && !rdWin && !rdZeroQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= HIF_UNINIT;
      wrWinQ  <= 1'b0;
      rdWinQ  <= 1'b0;
      rdZeroQ <= 1'b0;
    end else begin
      wrWinQ <= wrWin;
      rdWinQ <= rdWin;
      if (cfgNow) begin
        cfgQ <= HIF_READY;
      end
      if (rdStart) begin
        rdZeroQ <= !cfgNow;
      end
    end
  end

  always_comb begin
    strb.wrActive = wrWin;
    strb.wrCommit = wrCommit;
    strb.rdDrive  = rdWin;
    strb.rdZero   = rdStart ? !cfgNow : rdZeroQ;
    strb.popPulse = popPulse;
  end

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    popPulse |=> !popPulse); // R12

  AST_NO_POP_UNINIT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ == HIF_UNINIT) |-> !popPulse); // R10

endmodule

// File: rtl/hif_dpath.sv
module hif_dpath
  import hif_pkg::*;
#(
  parameter int DATA_W   = HIF_DATA_W,
  parameter int ADDR_W   = HIF_ADDR_W,
  parameter int NUM_REGS = HIF_NUM_REGS,
  parameter int MODE_REG = 1,
  parameter int MODE_BIT = 0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  hifStrobe_t                     strb,
  input  logic [DATA_W-1:0]              busIn,
  input  logic [ADDR_W-1:0]              regSel,
  input  logic [DATA_W-1:0]              fifoHead,
  output logic [DATA_W-1:0]              busOut,
  output logic                           busOe,
  output logic                           fifoPop,
  output logic                           sepMode,
  output logic [NUM_REGS-1:0][DATA_W-1:0] ctrlRegs
);

  logic [DATA_W-1:0] busInQ;
  logic [ADDR_W-1:0] regSelQ;
  logic [DATA_W-1:0] holdData;
  logic [ADDR_W-1:0] holdAddr;

  // same sampling stage as the strobe pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busInQ  <= '0;
      regSelQ <= '0;
    end else begin
      busInQ  <= busIn;
      regSelQ <= regSel;
    end
  end

  // last word and address seen inside the write window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdAddr <= '0;
    end else if (strb.wrActive) begin
      holdData <= busInQ;
      holdAddr <= regSelQ;
    end
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlRegs[gi] <= '0;
      end else if (strb.wrCommit && holdAddr == ADDR_W'(gi)) begin
        ctrlRegs[gi] <= holdData;
      end
    end
  end

  assign sepMode = ctrlRegs[MODE_REG][MODE_BIT];
  assign busOe   = strb.rdDrive;
  assign busOut  = (strb.rdDrive && !strb.rdZero) ? fifoHead : '0;
  assign fifoPop = strb.popPulse;

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCommit |=> $stable(ctrlRegs)); // R3

  AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrActive |-> !busOe); // R13

endmodule

// File: rtl/hif_host_port.sv
module hif_host_port
  import hif_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  selLoN,
  input  logic                  selHi,
  input  logic [HIF_ADDR_W-1:0] regSel,
  input  logic                  rwPin,
  input  logic                  rdPinN,
  input  logic [HIF_DATA_W-1:0] busIn,
  output logic [HIF_DATA_W-1:0] busOut,
  output logic                  busOe,
  input  logic [HIF_DATA_W-1:0] fifoHead,
  output logic                  fifoPop,
  output logic [HIF_DATA_W-1:0] ctrlReg0,
  output logic [HIF_DATA_W-1:0] ctrlReg1
);

  localparam int NUM_REGS = HIF_NUM_REGS;
  localparam int MODE_REG = NUM_REGS - 1;

  hifStrobe_t strb;
  logic       sepMode;
  logic [NUM_REGS-1:0][HIF_DATA_W-1:0] ctrlRegs;

  hif_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .selLoN  (selLoN),
    .selHi   (selHi),
    .rwPin   (rwPin),
    .rdPinN  (rdPinN),
    .sepMode (sepMode),
    .strb    (strb)
  );

  hif_dpath #(
    .DATA_W   (HIF_DATA_W),
    .ADDR_W   (HIF_ADDR_W),
    .NUM_REGS (NUM_REGS),
    .MODE_REG (MODE_REG),
    .MODE_BIT (0)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busIn    (busIn),
    .regSel   (regSel),
    .fifoHead (fifoHead),
    .busOut   (busOut),
    .busOe    (busOe),
    .fifoPop  (fifoPop),
    .sepMode  (sepMode),
    .ctrlRegs (ctrlRegs)
  );

  assign ctrlReg0 = ctrlRegs[0];
  assign ctrlReg1 = ctrlRegs[1];

  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !($past(!selLoN && selHi)) |-> !busOe); // R2

  AST_POP_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !busOe); // R6

endmodule

// File: tb/hif_host_port_test.sv
module hif_host_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selLoN = 1'b1;
  logic       selHi = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       rwPin = 1'b1;
  logic       rdPinN = 1'b1;
  logic [9:0] busIn = 10'd0;
  logic [9:0] busOut;
  logic       busOe;
  logic [9:0] fifoHead;
  logic       fifoPop;
  logic [9:0] ctrlReg0;
  logic [9:0] ctrlReg1;

  int checks = 0;
  int errors = 0;
  int popCnt = 0;

  always #4 clk = ~clk;

  hif_host_port uut (
    .clk(clk), .rstN(rstN), .selLoN(selLoN), .selHi(selHi), .regSel(regSel),
    .rwPin(rwPin), .rdPinN(rdPinN), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .fifoHead(fifoHead), .fifoPop(fifoPop), .ctrlReg0(ctrlReg0), .ctrlReg1(ctrlReg1)
  );

  function automatic logic [9:0] headAt(input int n);
    return 10'(10'h2C3 + n * 7);
  endfunction

  assign fifoHead = headAt(popCnt);

  always @(negedge clk) if (fifoPop) popCnt <= popCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    selLoN = 1'b1; selHi = 1'b0; rwPin = 1'b1; rdPinN = 1'b1; busIn = 10'h3FF;
  endtask

  // endHow: 0 raise selLoN, 1 drop selHi
  task automatic doWrite(input logic [1:0] a, input logic [9:0] d,
                         input int endHow, input logic rdLevel);
    @(negedge clk);
    regSel = a; busIn = d; rwPin = 1'b0; rdPinN = rdLevel; selLoN = 1'b0; selHi = 1'b1;
    repeat (3) @(negedge clk);
    if (endHow == 0) selLoN = 1'b1; else selHi = 1'b0;
    repeat (4) @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic doRead(input bit useRd, input int holdCycles,
                        output logic oe, output logic [9:0] val, output int pops);
    int p0;
    @(negedge clk);
    p0 = popCnt;
    selLoN = 1'b0; selHi = 1'b1; rwPin = 1'b1; rdPinN = useRd ? 1'b0 : 1'b1;
    repeat (holdCycles) @(negedge clk);
    oe = busOe; val = busOut;
    @(negedge clk);
    idle();
    repeat (4) @(negedge clk);
    pops = popCnt - p0;
  endtask

  task automatic testReset();
    check(ctrlReg0 == 10'h0, "R1", "ctrlReg0 after reset", ctrlReg0, 0);
    check(ctrlReg1 == 10'h0, "R1", "ctrlReg1 after reset", ctrlReg1, 0);
    check(busOe == 1'b0, "R1", "busOe after reset", busOe, 0);
    check(fifoPop == 1'b0, "R1", "fifoPop after reset", fifoPop, 0);
    check(busOut == 10'h0, "R11", "busOut idle", busOut, 0);
  endtask

  task automatic testReadBeforeWrite();
    logic oe; logic [9:0] v; int p;
    doRead(1'b0, 3, oe, v, p);
    check(oe == 1'b1, "R10", "early read oe", oe, 1);
    check(v == 10'h0, "R10", "early read data", v, 0);
    check(p == 0, "R10", "early read pops", p, 0);
    doRead(1'b1, 3, oe, v, p);
    check(oe == 1'b1 && v == 10'h0, "R10", "early strobe read data", v, 0);
    check(p == 0, "R10", "early strobe read pops", p, 0);
  endtask

  task automatic testDeselected();
    logic oe; logic [9:0] v; int p;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      regSel = 2'd0; busIn = 10'h1AB; rwPin = 1'b0;
      selLoN = (k == 0) ? 1'b1 : 1'b0;
      selHi  = (k == 0) ? 1'b1 : 1'b0;
      repeat (4) @(negedge clk);
      idle();
      repeat (4) @(negedge clk);
      check(ctrlReg0 == 10'h0, "R2", "reg0 after deselected write", ctrlReg0, 0);
    end
    doRead(1'b0, 3, oe, v, p);
    check(v == 10'h0 && p == 0, "R2", "still unconfigured read", v, 0);
  endtask

  task automatic testCombinedWrite();
    doWrite(2'd0, 10'h155, 0, 1'b1);
    check(ctrlReg0 == 10'h155, "R3", "reg0 via selLoN end", ctrlReg0, 10'h155);
    doWrite(2'd1, 10'h2A0, 1, 1'b1);
    check(ctrlReg1 == 10'h2A0, "R3", "reg1 via selHi end", ctrlReg1, 10'h2A0);
    check(ctrlReg0 == 10'h155, "R3", "reg0 untouched", ctrlReg0, 10'h155);
  endtask

  task automatic testBadAddress();
    doWrite(2'd2, 10'h3FF, 0, 1'b1);
    doWrite(2'd3, 10'h0AA, 0, 1'b1);
    check(ctrlReg0 == 10'h155, "R4", "reg0 after addr 2/3", ctrlReg0, 10'h155);
    check(ctrlReg1 == 10'h2A0, "R4", "reg1 after addr 2/3", ctrlReg1, 10'h2A0);
  endtask

  task automatic testCombinedRead();
    logic oe; logic [9:0] v; int p; logic [9:0] exp;
    exp = headAt(popCnt);
    doRead(1'b0, 10, oe, v, p);
    check(oe == 1'b1, "R6", "combined read oe", oe, 1);
    check(v == exp, "R6", "combined read data", v, exp);
    check(p == 1, "R12", "pops for long read", p, 1);
    check(busOe == 1'b0 && busOut == 10'h0, "R11", "bus released", busOut, 0);
  endtask

  task automatic testRdIgnored();
    int p0;
    p0 = popCnt;
    doWrite(2'd0, 10'h0F0, 0, 1'b0);
    check(ctrlReg0 == 10'h0F0, "R9", "write with rdPinN low", ctrlReg0, 10'h0F0);
    @(negedge clk);
    rdPinN = 1'b0;
    repeat (4) @(negedge clk);
    check(busOe == 1'b0, "R9", "rdPinN alone drives", busOe, 0);
    idle();
    repeat (4) @(negedge clk);
    check(popCnt - p0 == 0, "R9", "pops from rdPinN", popCnt - p0, 0);
  endtask

  task automatic testModeSwitch();
    logic oe; logic [9:0] v; int p;
    doWrite(2'd1, 10'h001, 0, 1'b1);
    check(ctrlReg1 == 10'h001, "R5", "mode bit written", ctrlReg1, 1);
    doRead(1'b0, 3, oe, v, p);
    check(oe == 1'b0, "R5", "rw high without rdPinN in split mode", oe, 0);
    check(p == 0, "R5", "no pop without rdPinN", p, 0);
  endtask

  task automatic testSeparateWrite();
    @(negedge clk);
    regSel = 2'd0; busIn = 10'h1E1; rwPin = 1'b0; selLoN = 1'b0; selHi = 1'b1;
    repeat (3) @(negedge clk);
    rwPin = 1'b1;
    repeat (4) @(negedge clk);
    check(ctrlReg0 == 10'h1E1, "R7", "reg0 on rwPin rise", ctrlReg0, 10'h1E1);
    check(busOe == 1'b0, "R7", "no drive after write strobe", busOe, 0);
    idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic testSeparateRead();
    logic oe; logic [9:0] v; int p; logic [9:0] exp;
    exp = headAt(popCnt);
    doRead(1'b1, 6, oe, v, p);
    check(oe == 1'b1 && v == exp, "R8", "split read data", v, exp);
    check(p == 1, "R8", "split read pops", p, 1);
  endtask

  task automatic testWritePriority();
    int p0;
    p0 = popCnt;
    @(negedge clk);
    regSel = 2'd1; busIn = 10'h003; rwPin = 1'b0; rdPinN = 1'b0; selLoN = 1'b0; selHi = 1'b1;
    repeat (3) @(negedge clk);
    check(busOe == 1'b0, "R13", "drive during write+read", busOe, 0);
    selLoN = 1'b1;
    repeat (4) @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    check(ctrlReg1 == 10'h003, "R13", "reg1 written", ctrlReg1, 10'h003);
    check(popCnt - p0 == 0, "R13", "pops", popCnt - p0, 0);
  endtask

  task automatic testCollision();
    int p0; logic [9:0] exp;
    p0 = popCnt;
    exp = headAt(popCnt);
    @(negedge clk);
    regSel = 2'd0; busIn = 10'h2DD; rwPin = 1'b0; rdPinN = 1'b1; selLoN = 1'b0; selHi = 1'b1;
    repeat (3) @(negedge clk);
    rwPin = 1'b1; rdPinN = 1'b0;
    repeat (3) @(negedge clk);
    check(ctrlReg0 == 10'h2DD, "R7", "collision write", ctrlReg0, 10'h2DD);
    check(busOe == 1'b1 && busOut == exp, "R8", "collision read data", busOut, exp);
    idle();
    repeat (4) @(negedge clk);
    check(popCnt - p0 == 1, "R8", "collision pops", popCnt - p0, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadBeforeWrite();
    testDeselected();
    testCombinedWrite();
    testBadAddress();
    testCombinedRead();
    testRdIgnored();
    testModeSwitch();
    testSeparateWrite();
    testSeparateRead();
    testWritePriority();
    testCollision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule